// File: doc/BRIEF.md
# PRBS Bit-Error Checker with Self-Aligning Sync

The block watches a received parallel data stream and measures its bit error rate against a pseudo-random binary sequence. Any of nine common PRBS polynomials can be selected. The checker needs no start-up state and no alignment from outside. It loads its local sequence generator straight from the first received bits. It then runs freely from that state and predicts every following bit.

Before any error is counted, the checker runs a sync window. It compares a programmed number of bits and accepts the alignment only if the errors in that window stay below a programmed limit. If the limit is reached, the checker reloads its generator from fresh received data and opens a new window. Once locked, it counts compared bits and bit errors over a programmed duration and then stops (single shot). In repeat mode it keeps counting without end.

Top module: `prbs_sync_checker`

## Requirements
- R1: `polySel` picks the sequence. Each bit is the XOR of the earlier stream bits at these delays: 0 = {5,3}, 1 = {7,6}, 2 = {9,5}, 3 = {11,9}, 4 = {13,12,2,1}, 5 = {15,14}, 6 = {21,19}, 7 = {23,18}, 8 and above = {31,28}. Within a word, `dataIn[0]` is the earliest bit in time.
- R2: After reset, and after every failed sync window, the first ceil(D/W) valid words are loaded into the local generator without being compared. D is the degree of the selected polynomial. The generator then runs freely and compares every following valid word.
- R3: `syncLocked` rises in the cycle after the valid word that brings the bits compared in the sync window to at least max(`sampleBits`, 1024), provided the errors in the window stay below the effective threshold.
- R4: The effective threshold is max(`errThresh`, 3). When the window error total reaches it, the checker goes back to loading. This takes priority over the end of the window.
- R5: While locked, each valid word adds W to `bitCount` and adds the number of its bits that differ from the prediction to `errCount`. Both counters stay at zero until lock.
- R6: In single-shot mode (`repeatMode` = 0), `done` rises after the word that brings `bitCount` to 32 × max(`durUnits`, 1). From then on, neither counter changes until reset.
- R7: In repeat mode (`repeatMode` = 1), `done` never asserts and counting goes on past the programmed duration.
- R8: `errCount` saturates at its all-ones value instead of wrapping.
- R9: A cycle with `dataValid` low changes no counter and no checker state, whatever `dataIn` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also restarts a measurement |
| dataIn | input | W | Received data word, bit 0 earliest |
| dataValid | input | 1 | Qualifies `dataIn` |
| polySel | input | 4 | Polynomial code (R1) |
| errThresh | input | THR_W | Sync window error limit, floor 3 |
| sampleBits | input | SAMP_W | Sync window length in bits, floor 1024 |
| durUnits | input | DUR_W | Single-shot length in 32-bit units, 0 treated as 1 |
| repeatMode | input | 1 | 1 = count continuously |
| syncLocked | output | 1 | Alignment accepted |
| errCount | output | ERR_W | Saturating bit error count |
| bitCount | output | BIT_W | Bits compared since lock |
| done | output | 1 | Single-shot duration complete |

## Verification
The bench places errors in the sync window at exactly one below the threshold and at exactly the threshold. An off-by-one in the threshold compare either reseeds a good link or accepts a bad one, and in both cases the lock cycle moves. Programmed values below the floors check the clamps; without them the checker locks after a few words or on a single error. Inverted data drives the narrowed error counter past full scale, which catches a wrapping counter. A zero duration, repeat mode and words sent after `done` check that the stop point is exact and that counting stays frozen once finished. Idle cycles with garbage on the data lines check that nothing moves without `dataValid`.

// File: rtl/prbschk_pkg.sv
package prbschk_pkg;

  localparam int HIST_W = 31;

  typedef enum logic [1:0] {
    ST_SEED,
    ST_SYNC,
    ST_LOCK,
    ST_DONE
  } chkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHist;  // shift received bits into the generator
    logic runHist;   // advance the generator on its own prediction
    logic syncClr;   // clear sync window accumulators
    logic syncAcc;   // accumulate the current word into the sync window
    logic cntAcc;    // accumulate the current word into the measurement
  } dpStrobe_t;

  // feedback delays of each selectable sequence, bit k-1 = delay k
  function automatic logic [HIST_W-1:0] tapMask(input logic [3:0] sel);
    logic [HIST_W-1:0] m;
    m = '0;
    case (sel)
      4'd0: begin m[4]  = 1'b1; m[2]  = 1'b1; end
      4'd1: begin m[6]  = 1'b1; m[5]  = 1'b1; end
      4'd2: begin m[8]  = 1'b1; m[4]  = 1'b1; end
      4'd3: begin m[10] = 1'b1; m[8]  = 1'b1; end
      4'd4: begin m[12] = 1'b1; m[11] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
      4'd5: begin m[14] = 1'b1; m[13] = 1'b1; end
      4'd6: begin m[20] = 1'b1; m[18] = 1'b1; end
      4'd7: begin m[22] = 1'b1; m[17] = 1'b1; end
      default: begin m[30] = 1'b1; m[27] = 1'b1; end
    endcase
    return m;
  endfunction

  function automatic int unsigned polyDegree(input logic [3:0] sel);
    case (sel)
      4'd0: return 5;
      4'd1: return 7;
      4'd2: return 9;
      4'd3: return 11;
      4'd4: return 13;
      4'd5: return 15;
      4'd6: return 21;
      4'd7: return 23;
      default: return 31;
    endcase
  endfunction

endpackage

// File: rtl/prbschk_dp.sv
module prbschk_dp
  import prbschk_pkg::*;
#(
  parameter int W      = 8,
  parameter int ERR_W  = 32,
  parameter int BIT_W  = 40,
  parameter int THR_W  = 16,
  parameter int SAMP_W = 32,
  parameter int CW     = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      dataIn,
  input  logic [3:0]        polySel,
  input  dpStrobe_t         stb,
  output logic [CW-1:0]     wordErr,
  output logic [THR_W-1:0]  syncErr,
  output logic [SAMP_W:0]   syncBits,
  output logic [ERR_W-1:0]  errCount,
  output logic [BIT_W-1:0]  bitCount
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [THR_W-1:0] THR_MAX = '1;

  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] histRun;
  logic [HIST_W-1:0] histLoad;
  logic [HIST_W-1:0] mask;
  logic [W-1:0]      expWord;
  logic [W-1:0]      diffWord;
  logic [ERR_W:0]    errSum;
  logic [THR_W:0]    syncSum;

  assign mask = tapMask(polySel);

  // free-running prediction of the next W bits
  always_comb begin
    histRun = hist;
    for (int i = 0; i < W; i++) begin
      expWord[i] = ^(histRun & mask);
      histRun    = {histRun[HIST_W-2:0], expWord[i]};
    end
  end

  // loading the generator straight from received bits
  always_comb begin
    histLoad = hist;
    for (int i = 0; i < W; i++) begin
      histLoad = {histLoad[HIST_W-2:0], dataIn[i]};
    end
  end

  assign diffWord = dataIn ^ expWord;

  always_comb begin
    wordErr = '0;
    for (int i = 0; i < W; i++) begin
      wordErr = wordErr + CW'(diffWord[i]);
    end
  end

  assign errSum  = {1'b0, errCount} + (ERR_W + 1)'(wordErr);
  assign syncSum = {1'b0, syncErr} + (THR_W + 1)'(wordErr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (stb.loadHist) begin
      hist <= histLoad;
    end else if (stb.runHist) begin
      hist <= histRun;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncErr  <= '0;
      syncBits <= '0;
    end else if (stb.syncClr) begin
      syncErr  <= '0;
      syncBits <= '0;
    end else if (stb.syncAcc) begin
      syncErr  <= syncSum[THR_W] ? THR_MAX : syncSum[THR_W-1:0];
      syncBits <= syncBits + (SAMP_W + 1)'(W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errCount <= '0;
      bitCount <= '0;
    end else if (stb.cntAcc) begin
      errCount <= errSum[ERR_W] ? ERR_MAX : errSum[ERR_W-1:0];
      bitCount <= bitCount + BIT_W'(W);
    end
  end

  AST_ERR_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (errCount == ERR_MAX) |=> (errCount == ERR_MAX)); // R8

  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bitCount != $past(bitCount)) |-> (bitCount == $past(bitCount) + BIT_W'(W))); // R5

endmodule

// File: rtl/prbschk_ctrl.sv
module prbschk_ctrl
  import prbschk_pkg::*;
#(
  parameter int W      = 8,
  parameter int THR_W  = 16,
  parameter int SAMP_W = 32,
  parameter int DUR_W  = 29,
  parameter int BIT_W  = 40,
  parameter int CW     = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dataValid,
  input  logic [3:0]        polySel,
  input  logic [THR_W-1:0]  errThresh,
  input  logic [SAMP_W-1:0] sampleBits,
  input  logic [DUR_W-1:0]  durUnits,
  input  logic              repeatMode,
  input  logic [CW-1:0]     wordErr,
  input  logic [THR_W-1:0]  syncErr,
  input  logic [SAMP_W:0]   syncBits,
  input  logic [BIT_W-1:0]  bitCount,
  output dpStrobe_t         stb,
  output logic              locked,
  output logic              done
);

  localparam int MIN_THR  = 3;
  localparam int MIN_SAMP = 1024;
  localparam int TGT_W    = DUR_W + 5;

  chkState_t st, stNext;
  logic [5:0] seedCnt, seedNext, seedWords;

  logic [THR_W-1:0]  thrEff;
  logic [SAMP_W-1:0] sampEff;
  logic [DUR_W-1:0]  durEff;
  logic [TGT_W-1:0]  targetBits;
  logic [THR_W:0]    errNext;
  logic [SAMP_W+1:0] syncBitsNext;
  logic [BIT_W:0]    bitsNext;
  logic              thrHit, windowFull, durReached;

  assign seedWords  = 6'((polyDegree(polySel) + W - 1) / W);
  assign thrEff     = (errThresh < THR_W'(MIN_THR)) ? THR_W'(MIN_THR) : errThresh;
  assign sampEff    = (sampleBits < SAMP_W'(MIN_SAMP)) ? SAMP_W'(MIN_SAMP) : sampleBits;
  assign durEff     = (durUnits == '0) ? DUR_W'(1) : durUnits;
  assign targetBits = {durEff, 5'b00000};

  assign errNext      = {1'b0, syncErr} + (THR_W + 1)'(wordErr);
  assign syncBitsNext = {1'b0, syncBits} + (SAMP_W + 2)'(W);
  assign bitsNext     = {1'b0, bitCount} + (BIT_W + 1)'(W);

  assign thrHit     = errNext >= {1'b0, thrEff};
  assign windowFull = syncBitsNext >= (SAMP_W + 2)'(sampEff);
  assign durReached = bitsNext >= (BIT_W + 1)'(targetBits);

  always_comb begin
    stb      = '0;
    stNext   = st;
    seedNext = seedCnt;
    case (st)
      ST_SEED: begin
        if (dataValid) begin
          stb.loadHist = 1'b1;
          if (seedCnt + 6'd1 >= seedWords) begin
            stNext      = ST_SYNC;
            seedNext    = '0;
            stb.syncClr = 1'b1;
          end else begin
            seedNext = seedCnt + 6'd1;
          end
        end
      end
      ST_SYNC: begin
        if (dataValid) begin
          stb.runHist = 1'b1;
          stb.syncAcc = 1'b1;
          if (thrHit) begin
            stNext = ST_SEED;
          end else if (windowFull) begin
            stNext = ST_LOCK;
          end
        end
      end
      ST_LOCK: begin
        if (dataValid) begin
          stb.runHist = 1'b1;
          stb.cntAcc  = 1'b1;
          if (!repeatMode && durReached) begin
            stNext = ST_DONE;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_SEED;
      seedCnt <= '0;
    end else begin
      st      <= stNext;
      seedCnt <= seedNext;
    end
  end

  assign locked = (st == ST_LOCK) || (st == ST_DONE);
  assign done   = (st == ST_DONE);

  AST_SYNC_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SYNC) |-> ({1'b0, syncErr} < {1'b0, thrEff})); // R4

  AST_LOCK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(syncBitsNext) >= (SAMP_W + 2)'($past(sampEff)))); // R3

  AST_REPEAT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (repeatMode && $past(repeatMode) && !$past(done)) |-> !done); // R7

endmodule

// File: rtl/prbs_sync_checker.sv
module prbs_sync_checker
  import prbschk_pkg::*;
#(
  parameter int W      = 8,
  parameter int ERR_W  = 32,
  parameter int BIT_W  = 40,
  parameter int THR_W  = 16,
  parameter int SAMP_W = 32,
  parameter int DUR_W  = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      dataIn,
  input  logic              dataValid,
  input  logic [3:0]        polySel,
  input  logic [THR_W-1:0]  errThresh,
  input  logic [SAMP_W-1:0] sampleBits,
  input  logic [DUR_W-1:0]  durUnits,
  input  logic              repeatMode,
  output logic              syncLocked,
  output logic [ERR_W-1:0]  errCount,
  output logic [BIT_W-1:0]  bitCount,
  output logic              done
);

  localparam int CW = $clog2(W + 1);

  dpStrobe_t          stb;
  logic [CW-1:0]      wordErr;
  logic [THR_W-1:0]   syncErr;
  logic [SAMP_W:0]    syncBits;

  prbschk_ctrl #(
    .W(W), .THR_W(THR_W), .SAMP_W(SAMP_W), .DUR_W(DUR_W), .BIT_W(BIT_W), .CW(CW)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .dataValid(dataValid), .polySel(polySel),
    .errThresh(errThresh), .sampleBits(sampleBits), .durUnits(durUnits),
    .repeatMode(repeatMode), .wordErr(wordErr), .syncErr(syncErr),
    .syncBits(syncBits), .bitCount(bitCount), .stb(stb),
    .locked(syncLocked), .done(done)
  );

  prbschk_dp #(
    .W(W), .ERR_W(ERR_W), .BIT_W(BIT_W), .THR_W(THR_W), .SAMP_W(SAMP_W), .CW(CW)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .dataIn(dataIn), .polySel(polySel), .stb(stb),
    .wordErr(wordErr), .syncErr(syncErr), .syncBits(syncBits),
    .errCount(errCount), .bitCount(bitCount)
  );

  AST_NO_COUNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !syncLocked |-> (bitCount == '0 && errCount == '0)); // R5

  AST_CNT_FROZEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(bitCount) && $stable(errCount))); // R6

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !dataValid |=> ($stable(bitCount) && $stable(errCount) && $stable(syncLocked))); // R9

endmodule

// File: tb/prbs_sync_checker_tb_top.sv
module prbs_sync_checker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int ERR_W = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [W-1:0]      dataIn = '0;
  logic              dataValid = 1'b0;
  logic [3:0]        polySel = '0;
  logic [15:0]       errThresh = '0;
  logic [31:0]       sampleBits = '0;
  logic [28:0]       durUnits = '0;
  logic              repeatMode = 1'b0;
  logic              syncLocked;
  logic [ERR_W-1:0]  errCount;
  logic [39:0]       bitCount;
  logic              done;

  int nChecks = 0;
  int nErrs = 0;
  logic [30:0] bh;
  logic [3:0]  curSel;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prbs_sync_checker #(.W(W), .ERR_W(ERR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .dataIn(dataIn), .dataValid(dataValid),
    .polySel(polySel), .errThresh(errThresh), .sampleBits(sampleBits),
    .durUnits(durUnits), .repeatMode(repeatMode), .syncLocked(syncLocked),
    .errCount(errCount), .bitCount(bitCount), .done(done)
  );

  function automatic int bDeg(input logic [3:0] s);
    int d[9] = '{5, 7, 9, 11, 13, 15, 21, 23, 31};
    return (s > 4'd8) ? 31 : d[s];
  endfunction

  function automatic logic [30:0] bTaps(input logic [3:0] s);
    logic [30:0] t;
    t = '0;
    case (bDeg(s))
      5:  t = (31'd1 << 4)  | (31'd1 << 2);
      7:  t = (31'd1 << 6)  | (31'd1 << 5);
      9:  t = (31'd1 << 8)  | (31'd1 << 4);
      11: t = (31'd1 << 10) | (31'd1 << 8);
      13: t = (31'd1 << 12) | (31'd1 << 11) | 31'd2 | 31'd1;
      15: t = (31'd1 << 14) | (31'd1 << 13);
      21: t = (31'd1 << 20) | (31'd1 << 18);
      23: t = (31'd1 << 22) | (31'd1 << 17);
      default: t = (31'd1 << 30) | (31'd1 << 27);
    endcase
    return t;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic genWord(output logic [W-1:0] w);
    logic e;
    for (int i = 0; i < W; i++) begin
      e = ^(bh & bTaps(curSel));
      bh = {bh[29:0], e};
      w[i] = e;
    end
  endtask

  task automatic startRun(input logic [3:0] s, input int thr, input int samp,
                          input int dur, input bit rep);
    logic [30:0] dm;
    rst_n = 1'b0;
    dataValid = 1'b0;
    polySel = s; curSel = s;
    errThresh = 16'(thr); sampleBits = 32'(samp);
    durUnits = 29'(dur); repeatMode = rep;
    dm = (31'd1 << bDeg(s)) - 31'd1;
    if (bDeg(s) == 31) dm = '1;
    bh = 31'($urandom);
    if ((bh & dm) == '0) bh[0] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one word, flipped by 'flip', after an optional idle gap with garbage on the bus
  task automatic sendWord(input logic [W-1:0] flip);
    logic [W-1:0] w;
    if ($urandom_range(0, 3) == 0) begin
      dataIn = W'($urandom);
      repeat ($urandom_range(1, 2)) @(negedge clk);
    end
    genWord(w);
    dataIn = w ^ flip;
    dataValid = 1'b1;
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic sendClean(input int n);
    for (int i = 0; i < n; i++) sendWord('0);
  endtask

  function automatic int seedW(input logic [3:0] s);
    return (bDeg(s) + W - 1) / W;
  endfunction

  initial begin
    void'($urandom(32'd20240611));

    // reset state
    startRun(4'd1, 3, 1024, 8, 1'b0);
    chk("R5 reset bitCount", bitCount, 0);
    chk("R5 reset errCount", errCount, 0);
    chk("R3 reset syncLocked", syncLocked, 0);
    chk("R6 reset done", done, 0);

    // PRBS7 single shot, exact lock cycle and exact stop point
    sendClean(seedW(4'd1) + 127);
    chk("R3 not locked one word early", syncLocked, 0);
    sendClean(1);
    chk("R2 R3 locked after seed plus window", syncLocked, 1);
    chk("R5 no bits before first locked word", bitCount, 0);
    sendClean(2);
    dataIn = 8'hA5;
    repeat (4) @(negedge clk);
    chk("R9 idle leaves bitCount", bitCount, 16);
    chk("R9 idle leaves errCount", errCount, 0);
    sendClean(29);
    chk("R6 done not yet", done, 0);
    chk("R5 bitCount before end", bitCount, 248);
    sendClean(1);
    chk("R6 done at duration", done, 1);
    chk("R6 bitCount at duration", bitCount, 256);
    for (int i = 0; i < 5; i++) sendWord(8'h0F);
    chk("R6 frozen bitCount", bitCount, 256);
    chk("R6 frozen errCount", errCount, 0);

    // random runs over all polynomials with random error patterns
    for (int p = 0; p <= 9; p++) begin
      int samp, dur, lockAt, expErr;
      logic [W-1:0] f;
      samp = 1024 + $urandom_range(0, 200);
      dur = $urandom_range(4, 20);
      startRun(4'(p), 3, samp, dur, 1'b0);
      lockAt = seedW(4'(p)) + (samp + W - 1) / W;
      sendClean(lockAt - 1);
      chk("R1 R3 random run locked early", syncLocked, 0);
      sendClean(1);
      chk("R1 R3 random run lock", syncLocked, 1);
      expErr = 0;
      for (int i = 0; i < dur * 32 / W; i++) begin
        f = ($urandom_range(0, 4) == 0) ? W'($urandom & $urandom) : '0;
        expErr += $countones(f);
        sendWord(f);
      end
      chk("R5 random errCount", errCount, expErr);
      chk("R5 random bitCount", bitCount, dur * 32);
      chk("R6 random done", done, 1);
    end

    // threshold minus one errors in window: still locks on time
    startRun(4'd2, 5, 1024, 4, 1'b0);
    sendClean(seedW(4'd2));
    for (int i = 0; i < 4; i++) sendWord(8'h01);
    sendClean(128 - 4 - 1);
    chk("R4 below threshold not yet", syncLocked, 0);
    sendClean(1);
    chk("R4 below threshold locks", syncLocked, 1);

    // errors reaching threshold: reseed and a full new window
    startRun(4'd2, 5, 1024, 4, 1'b0);
    sendClean(seedW(4'd2));
    for (int i = 0; i < 5; i++) sendWord(8'h10);
    sendClean(seedW(4'd2) + 127);
    chk("R4 threshold reseeds, no lock yet", syncLocked, 0);
    sendClean(1);
    chk("R2 R4 lock after reseed", syncLocked, 1);

    // floors: threshold 1 acts as 3, window 16 acts as 1024
    startRun(4'd5, 1, 16, 4, 1'b0);
    sendClean(seedW(4'd5));
    sendWord(8'h80);
    sendWord(8'h02);
    sendClean(125);
    chk("R3 R4 floors, no early lock", syncLocked, 0);
    sendClean(1);
    chk("R3 R4 floors, lock", syncLocked, 1);

    // repeat mode runs past the duration
    startRun(4'd7, 3, 1024, 2, 1'b1);
    sendClean(seedW(4'd7) + 128);
    sendClean(40);
    chk("R7 repeat no done", done, 0);
    chk("R7 repeat bitCount", bitCount, 320);

    // zero duration means one unit
    startRun(4'd0, 3, 1024, 0, 1'b0);
    sendClean(seedW(4'd0) + 128);
    sendClean(3);
    chk("R6 zero duration not done", done, 0);
    sendClean(1);
    chk("R6 zero duration done", done, 1);
    chk("R6 zero duration bitCount", bitCount, 32);

    // saturation of the narrowed error counter
    startRun(4'd3, 3, 1024, 100, 1'b0);
    sendClean(seedW(4'd3) + 128);
    for (int i = 0; i < 127; i++) sendWord(8'hFF);
    chk("R8 exact below saturation", errCount, 1016);
    for (int i = 0; i < 4; i++) sendWord(8'hFF);
    chk("R8 saturated", errCount, 1023);

    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule